// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Driver with Unit Indicator

This block drives a row of six common-cathode seven-segment positions, one position at a time. Five positions show decimal digits, and any one of them can carry a lit decimal point. The sixth position shows no number. It lights a single horizontal segment that marks the unit of the reading: top for Hz, middle for kHz, bottom for MHz. The block has one 8-bit active-high segment bus and a 3-bit binary position code, which feeds an external 3-to-8 decoder that sinks the cathodes.

A prescaler divides the system clock, so each position is held for `TICK_DIV` clocks. The default suits a 2 ms slot at 50 MHz. The digit value, the decimal-point position and the unit each have their own load strobe, and each is staged in its own register. Staged values move to the display only at the start of a position. The first clock of every position is blanked, so the previous pattern does not ghost onto the newly selected cathode. Binary-to-decimal conversion is done elsewhere.

Top module: `seg_mux_driver`

## Requirements
- R1: While reset is asserted, `seg_out` is 8'h00 and `digit_sel` is 0.
- R2: `digit_sel` steps 0,1,2,3,4,5 and then wraps to 0. Codes 6 and 7 never appear.
- R3: Each `digit_sel` value is held for exactly `TICK_DIV` clock cycles.
- R4: `seg_out` is 8'h00 during the first clock of every position, which is the clock in which `digit_sel` has just changed.
- R5: Segment bits are active high: segment A on bit 0 through segment G on bit 6, decimal point on bit 7. Digit codes 0–9 give 3F,06,5B,4F,66,6D,7D,07,7F,6F (hex, before the point). Codes 10–15 give a blank glyph.
- R6: During the rest of position i (0–4), bits 6:0 show the glyph of `digit_bcd[4i+3:4i]`.
- R7: Bit 7 is set on numeric position i exactly when the point code equals i. Point codes 5, 6 and 7 light no point.
- R8: On position 5, unit code 0 gives 8'h00, 1 (Hz) gives 8'h01 (A), 2 (kHz) gives 8'h40 (G), and 3 (MHz) gives 8'h08 (D). The point is never lit there.
- R9: `digit_bcd`, `point_pos` and `unit_code` are taken only in a clock where their own strobe (`digit_load`, `point_load`, `unit_load`) is high. Otherwise those inputs are ignored, and the other two staged fields are kept.
- R10: A value loaded during a position first appears at the start of the next position. The position in progress keeps its pattern.
- After reset, the staged values are digits 0, point code 7 and unit code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| digit_load | input | 1 | Strobe that stages `digit_bcd` |
| digit_bcd | input | 20 | Five 4-bit digit codes, position i in bits 4i+3:4i |
| point_load | input | 1 | Strobe that stages `point_pos` |
| point_pos | input | 3 | Decimal point position, 0–4; 5–7 = none |
| unit_load | input | 1 | Strobe that stages `unit_code` |
| unit_code | input | 2 | 0 none, 1 Hz, 2 kHz, 3 MHz |
| seg_out | output | 8 | Segment bus, A..G on bits 0..6, point on bit 7 |
| digit_sel | output | 3 | Binary code of the active position, 0–5 |

## Verification
The assertions assume that `TICK_DIV` is at least 2. Otherwise a position would have no clock left after its blank clock. They also assume that strobes are single-clock pulses whose data is valid in the same clock. The bench uses `TICK_DIV` = 8. It raises each strobe for one clock in the middle of a position, never in the last clock before a boundary, and it drives deliberately different junk on the data inputs whenever the strobes are low. Over 240 positions, the loaded fields rotate across all 16 digit codes, all 8 point codes and all 4 unit codes.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int NUM_POS  = 5;
  localparam int UNIT_POS = 5;
  localparam int DIG_W    = 4;
  localparam int SEL_W    = 3;
  localparam int SEG_W    = 8;
  localparam int BUS_W    = NUM_POS * DIG_W;

  localparam logic [SEG_W-1:0] SEG_A  = 8'h01;
  localparam logic [SEG_W-1:0] SEG_D  = 8'h08;
  localparam logic [SEG_W-1:0] SEG_G  = 8'h40;
  localparam logic [SEG_W-1:0] SEG_DP = 8'h80;

  typedef enum logic [1:0] {
    UNIT_NONE = 2'd0,
    UNIT_HZ   = 2'd1,
    UNIT_KHZ  = 2'd2,
    UNIT_MHZ  = 2'd3
  } unit_e;

  typedef struct packed {
    logic [BUS_W-1:0] digits;
    logic [SEL_W-1:0] point;
    unit_e            unit;
  } disp_t;

  function automatic logic [SEG_W-1:0] digit_glyph(input logic [DIG_W-1:0] code);
    logic [SEG_W-1:0] g;
    case (code)
      4'd0:    g = 8'h3F;
      4'd1:    g = 8'h06;
      4'd2:    g = 8'h5B;
      4'd3:    g = 8'h4F;
      4'd4:    g = 8'h66;
      4'd5:    g = 8'h6D;
      4'd6:    g = 8'h7D;
      4'd7:    g = 8'h07;
      4'd8:    g = 8'h7F;
      4'd9:    g = 8'h6F;
      default: g = 8'h00;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/seg_slot_timer.sv
module seg_slot_timer #(
  parameter int TICK_DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = $clog2(TICK_DIV + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the slot counter stays inside one position length
  assert_cnt_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < TICK_DIV);
endmodule

// File: rtl/seg_position_seq.sv
module seg_position_seq
  import seg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [SEL_W-1:0] sel
);
  logic [SEL_W-1:0] sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (tick) sel_d = (sel_q == SEL_W'(UNIT_POS)) ? '0 : sel_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign sel = sel_q;

  assert_sel_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q <= SEL_W'(UNIT_POS));

  assert_sel_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sel_q == (($past(sel_q) == SEL_W'(UNIT_POS)) ? '0 : $past(sel_q) + 1'b1));

  assert_sel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sel_q));
endmodule

// File: rtl/seg_value_hold.sv
module seg_value_hold
  import seg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             digit_load,
  input  logic [BUS_W-1:0] digit_bcd,
  input  logic             point_load,
  input  logic [SEL_W-1:0] point_pos,
  input  logic             unit_load,
  input  logic [1:0]       unit_code,
  output disp_t            active
);
  disp_t stage_q, stage_d, act_q, act_d;
  disp_t rst_val;

  always_comb begin
    rst_val.digits = '0;
    rst_val.point  = '1;
    rst_val.unit   = UNIT_NONE;
  end

  always_comb begin
    stage_d = stage_q;
    if (digit_load) stage_d.digits = digit_bcd;
    if (point_load) stage_d.point  = point_pos;
    if (unit_load)  stage_d.unit   = unit_e'(unit_code);
    act_d = tick ? stage_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= rst_val;
      act_q   <= rst_val;
    end else begin
      stage_q <= stage_d;
      act_q   <= act_d;
    end
  end

  assign active = act_q;

  // R10: shown values change only at a position boundary
  assert_active_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(act_q));

  // R9: without its strobe a staged field keeps its value
  assert_digits_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !digit_load |=> $stable(stage_q.digits));
  assert_unit_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_load |=> $stable(stage_q.unit));
endmodule

// File: rtl/seg_glyph_enc.sv
module seg_glyph_enc
  import seg_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  disp_t            active,
  output logic [SEG_W-1:0] seg
);
  logic [SEG_W-1:0] num_glyph [NUM_POS];

  for (genvar g = 0; g < NUM_POS; g++) begin : g_num
    assign num_glyph[g] = digit_glyph(active.digits[g*DIG_W +: DIG_W])
                        | ((active.point == SEL_W'(g)) ? SEG_DP : '0);
  end

  always_comb begin
    seg = '0;
    for (int i = 0; i < NUM_POS; i++) begin
      if (sel == SEL_W'(i)) seg = num_glyph[i];
    end
    if (sel == SEL_W'(UNIT_POS)) begin
      case (active.unit)
        UNIT_HZ:  seg = SEG_A;
        UNIT_KHZ: seg = SEG_G;
        UNIT_MHZ: seg = SEG_D;
        default:  seg = '0;
      endcase
    end
  end
endmodule

// File: rtl/seg_mux_driver.sv
module seg_mux_driver
  import seg_pkg::*;
#(
  parameter int TICK_DIV = 100000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               digit_load,
  input  logic [BUS_W-1:0]   digit_bcd,
  input  logic               point_load,
  input  logic [SEL_W-1:0]   point_pos,
  input  logic               unit_load,
  input  logic [1:0]         unit_code,
  output logic [SEG_W-1:0]   seg_out,
  output logic [SEL_W-1:0]   digit_sel
);
  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  logic             tick;
  logic [SEL_W-1:0] sel;
  disp_t            active;
  logic [SEG_W-1:0] enc_seg;
  logic [SEG_W-1:0] seg_q, seg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  seg_slot_timer #(.TICK_DIV(TICK_DIV)) u_timer (
    .clk   (clk),
    .rst_n (rst_s_n),
    .tick  (tick)
  );

  seg_position_seq u_seq (
    .clk   (clk),
    .rst_n (rst_s_n),
    .tick  (tick),
    .sel   (sel)
  );

  seg_value_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .tick       (tick),
    .digit_load (digit_load),
    .digit_bcd  (digit_bcd),
    .point_load (point_load),
    .point_pos  (point_pos),
    .unit_load  (unit_load),
    .unit_code  (unit_code),
    .active     (active)
  );

  seg_glyph_enc u_enc (
    .sel    (sel),
    .active (active),
    .seg    (enc_seg)
  );

  always_comb seg_d = tick ? '0 : enc_seg;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) seg_q <= '0;
    else          seg_q <= seg_d;
  end

  assign seg_out   = seg_q;
  assign digit_sel = sel;

  // R4: the bus is dark in the clock the select code moves
  assert_blank_on_switch_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(digit_sel) |-> seg_out == '0);

  // R8: the unit position lights at most one of A, G, D and never the point
  assert_unit_shape_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    digit_sel == SEL_W'(UNIT_POS) |-> ($countones(seg_out) <= 1) && ((seg_out & 8'hB6) == '0));

  // R1: held reset keeps the outputs idle
  always_comb begin
    if (!rst_n) assert_reset_idle_R1: assert (seg_out == '0 && digit_sel == '0);
  end
endmodule

// File: tb/test_seg_mux_driver.sv
module test_seg_mux_driver;
  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 8;
  localparam int SLOTS      = 240;
  localparam int QUIET      = 24;

  logic        clk;
  logic        rst_n;
  logic        digit_load, point_load, unit_load;
  logic [19:0] digit_bcd;
  logic [2:0]  point_pos;
  logic [1:0]  unit_code;
  logic [7:0]  seg_out;
  logic [2:0]  digit_sel;

  int checks;
  int failures;
  logic [3:0] st_dig [5];
  logic [3:0] cm_dig [5];
  int st_dp, cm_dp, st_unit, cm_unit;

  seg_mux_driver #(.TICK_DIV(TICK)) i_seg_mux_driver (
    .clk        (clk),
    .rst_n      (rst_n),
    .digit_load (digit_load),
    .digit_bcd  (digit_bcd),
    .point_load (point_load),
    .point_pos  (point_pos),
    .unit_load  (unit_load),
    .unit_code  (unit_code),
    .seg_out    (seg_out),
    .digit_sel  (digit_sel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] glyph(input int v);
    case (v)
      0: return 8'h3F; 1: return 8'h06; 2: return 8'h5B; 3: return 8'h4F;
      4: return 8'h66; 5: return 8'h6D; 6: return 8'h7D; 7: return 8'h07;
      8: return 8'h7F; 9: return 8'h6F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] expect_seg(input int pos);
    if (pos == 5) begin
      case (cm_unit)
        1: return 8'h01;
        2: return 8'h40;
        3: return 8'h08;
        default: return 8'h00;
      endcase
    end
    return glyph(int'(cm_dig[pos])) | ((cm_dp == pos) ? 8'h80 : 8'h00);
  endfunction

  task automatic check_val(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_junk(input int s);
    digit_load = 1'b0; point_load = 1'b0; unit_load = 1'b0;
    digit_bcd  = {5{4'(15 - (s % 16))}};
    point_pos  = 3'(s + 3);
    unit_code  = 2'(s + 1);
  endtask

  task automatic apply_load(input int s);
    int field;
    field = s % 3;
    drive_junk(s);
    if (field == 0) begin
      for (int i = 0; i < 5; i++) begin
        st_dig[i] = 4'((s * 7 + i * 3) % 16);
        digit_bcd[i*4 +: 4] = st_dig[i];
      end
      digit_load = 1'b1;
    end else if (field == 1) begin
      st_dp = (s / 3) % 8;
      point_pos = 3'(st_dp);
      point_load = 1'b1;
    end else begin
      st_unit = (s / 3) % 4;
      unit_code = 2'(st_unit);
      unit_load = 1'b1;
    end
  endtask

  // precondition: at the falling edge just after digit_sel changed
  task automatic run_slot(input int pos, input int s, input bit do_load);
    string tag;
    for (int i = 0; i < 5; i++) cm_dig[i] = st_dig[i];
    cm_dp = st_dp;
    cm_unit = st_unit;
    check_val("R2", int'(digit_sel), pos);
    check_val("R4", int'(seg_out), 0);
    for (int k = 1; k < TICK; k++) begin
      if (do_load && k == TICK/2) apply_load(s);
      else drive_junk(s + k);
      @(negedge clk);
      if (!do_load) tag = "R9";
      else if (k > TICK/2) tag = "R10";
      else if (pos == 5) tag = "R8";
      else if (cm_dp == pos) tag = "R7";
      else if (cm_dig[pos] > 9) tag = "R5";
      else tag = "R6";
      check_val(tag, int'(seg_out), int'(expect_seg(pos)));
    end
    drive_junk(s);
    @(negedge clk);
    check_val("R3", int'(digit_sel), (pos + 1) % 6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int pos;
    int guard;
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    drive_junk(0);
    for (int i = 0; i < 5; i++) st_dig[i] = 4'd0;
    st_dp = 7;
    st_unit = 0;
    repeat (3) @(negedge clk);
    check_val("R1", int'(seg_out), 0);
    check_val("R1", int'(digit_sel), 0);
    rst_n = 1'b1;
    guard = 0;
    while (digit_sel != 3'd1 && guard < 4 * TICK + 8) begin
      @(negedge clk);
      guard++;
    end
    check_val("R2", int'(digit_sel), 1);
    pos = 1;
    for (int s = 0; s < SLOTS; s++) begin
      run_slot(pos, s, s < SLOTS - QUIET);
      pos = (pos + 1) % 6;
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule